// File: doc/BRIEF.md
# Double-Buffered Frame Fetch Address Generator

This block produces the sequence of word addresses that a display pipeline uses to read one frame of pixels out of memory. Software may load a pending frame base address at any moment; that pending value only becomes the active base when a frame-start pulse arrives, so the frame being read is never disturbed and panning between buffers is tear-free.

At each frame-start the block also captures a 32-bit transfer-size word (line count in the upper half, pixels per line in the lower half) and a pixel-size select. It then issues one request per 32-bit word with a valid/ready handshake, walking the frame linearly from the active base. Once the last word of the last line has been accepted it goes quiet until the next frame-start.

Top module: `fetch_addr_gen`

## Requirements
- R1: After reset the active base `cur_base` is 0, the pending base is 0 and `req_valid` is low.
- R2: A write on `nb_we` does not change `cur_base`; `cur_base` changes only on a cycle where `frame_start` is high.
- R3: On a `frame_start` cycle, `cur_base` takes the pending base; when the pending base was written several times since the last promotion, the most recent write is the one promoted. A write in the same cycle as `frame_start` is held for the following frame.
- R4: The first request after `frame_start` carries `cur_base`, and each accepted request (`req_valid` and `req_ready` high) advances `req_addr` by 4, continuously across line ends.
- R5: With `pix32` = 1 (four bytes per pixel, one pixel per word) a line is exactly H words, H being `xfer_cfg[15:0]`.
- R6: With `pix32` = 0 (two bytes per pixel, two pixels per word) a line is ceil(H/2) words.
- R7: After V lines (V = `xfer_cfg[31:16]`) have been accepted, `req_valid` stays low until the next `frame_start`.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_addr` holds.
- R9: When H or V is zero at `frame_start`, no request is issued for that frame.
- R10: A `frame_start` during an unfinished frame abandons it and restarts at the newly promoted base with the newly sampled sizes.
- R11: `xfer_cfg` and `pix32` are sampled only on `frame_start`; changing them mid-frame does not alter the current frame's request count.
- R12: Bits 1:0 of the written base are ignored; `cur_base[1:0]` and `req_addr[1:0]` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nb_we | input | 1 | Write strobe for the pending base |
| nb_wdata | input | ADDR_W | Pending base value |
| xfer_cfg | input | 32 | Line count [31:16], pixels per line [15:0] |
| pix32 | input | 1 | 1: four bytes per pixel, 0: two bytes per pixel |
| frame_start | input | 1 | Frame boundary pulse (promotes base, starts walk) |
| cur_base | output | ADDR_W | Base address of the frame in use |
| req_valid | output | 1 | Read request pending |
| req_addr | output | ADDR_W | Word address of the request |
| req_ready | input | 1 | Memory accepts the request |

## Verification
The checker watches on every cycle that the active base moves only at a frame boundary, that a stalled request holds its address, that accepted requests step by four, that a frame opens at the active base, and that addresses stay word-aligned. The bench's directed scenarios are needed for the counting behaviours: words per line in both pixel sizes, the end-of-frame stop, empty frames, last-write-wins promotion, mid-frame restart and the insensitivity to size changes within a frame.

// File: rtl/ffag_pkg.sv
package ffag_pkg;
    localparam int CNT_W      = 16;
    localparam int WORD_BYTES = 4;

    typedef struct packed {
        logic [CNT_W-1:0] lines;
        logic [CNT_W-1:0] hpix;
    } xfer_t;

    typedef struct packed {
        logic [CNT_W-1:0] words;
        logic [CNT_W-1:0] lines;
    } geom_t;

    // Words per line: one pixel per word in wide mode, two per word otherwise.
    function automatic logic [CNT_W-1:0] words_per_line(input logic [CNT_W-1:0] hpix,
                                                        input logic wide);
        logic [CNT_W:0] half;
        half = ({1'b0, hpix} + (CNT_W+1)'(1)) >> 1;
        return wide ? hpix : half[CNT_W-1:0];
    endfunction
endpackage

// File: rtl/ffag_base_dbuf.sv
module ffag_base_dbuf #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              promote,
    output logic [ADDR_W-1:0] pend_q,
    output logic [ADDR_W-1:0] active_q
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            active_q <= '0;
        end else begin
            if (we)
                pend_q <= wdata & ALIGN_MASK;
            if (promote)
                active_q <= pend_q;
        end
    end
endmodule

// File: rtl/ffag_walker.sv
module ffag_walker
    import ffag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  geom_t             geom,
    input  logic              ready,
    output logic              valid,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    geom_t            geom_q;
    logic [CNT_W-1:0] word_idx;
    logic [CNT_W-1:0] line_idx;
    logic             line_end;
    logic             frame_end;

    assign line_end  = (word_idx == geom_q.words - ONE);
    assign frame_end = line_end && (line_idx == geom_q.lines - ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= 1'b0;
            addr     <= '0;
            geom_q   <= '0;
            word_idx <= '0;
            line_idx <= '0;
        end else if (start) begin
            valid    <= (geom.words != '0) && (geom.lines != '0);
            addr     <= base;
            geom_q   <= geom;
            word_idx <= '0;
            line_idx <= '0;
        end else if (valid && ready) begin
            addr <= addr + STEP;
            if (line_end) begin
                word_idx <= '0;
                line_idx <= line_idx + ONE;
                if (frame_end)
                    valid <= 1'b0;
            end else begin
                word_idx <= word_idx + ONE;
            end
        end
    end
endmodule

// File: rtl/fetch_addr_gen.sv
module fetch_addr_gen
    import ffag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nb_we,
    input  logic [ADDR_W-1:0] nb_wdata,
    input  logic [31:0]       xfer_cfg,
    input  logic              pix32,
    input  logic              frame_start,
    output logic [ADDR_W-1:0] cur_base,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              req_ready
);
    logic [ADDR_W-1:0] pend_base;
    xfer_t             xfer;
    geom_t             geom;

    assign xfer       = xfer_t'(xfer_cfg);
    assign geom.words = words_per_line(xfer.hpix, pix32);
    assign geom.lines = xfer.lines;

    ffag_base_dbuf #(.ADDR_W(ADDR_W)) i_dbuf (
        .clk      (clk),
        .rst      (rst),
        .we       (nb_we),
        .wdata    (nb_wdata),
        .promote  (frame_start),
        .pend_q   (pend_base),
        .active_q (cur_base)
    );

    ffag_walker #(.ADDR_W(ADDR_W)) i_walk (
        .clk   (clk),
        .rst   (rst),
        .start (frame_start),
        .base  (pend_base),
        .geom  (geom),
        .ready (req_ready),
        .valid (req_valid),
        .addr  (req_addr)
    );
endmodule

// File: rtl/fetch_addr_gen_chk.sv
module fetch_addr_gen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_start,
    input logic [ADDR_W-1:0] cur_base,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ready
);
    assert_base_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(cur_base));

    assert_open_at_base_R4: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (!req_valid || req_addr == cur_base));

    assert_step_four_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !frame_start) |=>
            (!req_valid || req_addr == $past(req_addr) + ADDR_W'(4)));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !frame_start) |=> (req_valid && $stable(req_addr)));

    assert_aligned_R12: assert property (@(posedge clk) disable iff (rst)
        (req_addr[1:0] == 2'b00) && (cur_base[1:0] == 2'b00));
endmodule

bind fetch_addr_gen fetch_addr_gen_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .cur_base    (cur_base),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_ready   (req_ready)
);

// File: tb/test_fetch_addr_gen.sv
module test_fetch_addr_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        nb_we;
    logic [31:0] nb_wdata;
    logic [31:0] xfer_cfg;
    logic        pix32;
    logic        frame_start;
    logic [31:0] cur_base;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        req_ready;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    fetch_addr_gen #(.ADDR_W(32)) i_fetch_addr_gen (
        .clk(clk), .rst(rst), .nb_we(nb_we), .nb_wdata(nb_wdata),
        .xfer_cfg(xfer_cfg), .pix32(pix32), .frame_start(frame_start),
        .cur_base(cur_base), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_base(input logic [31:0] v);
        @(negedge clk); nb_we = 1'b1; nb_wdata = v;
        @(negedge clk); nb_we = 1'b0;
    endtask

    task automatic pulse_fs();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    // Positioned just after the frame-start edge; ready held high.
    task automatic collect(input logic [31:0] base, input int exp_n, input string req);
        int  got = 0;
        bit  ok  = 1'b1;
        logic [31:0] bad = '0;
        req_ready = 1'b1;
        for (int i = 0; i < exp_n + 4; i++) begin
            if (req_valid) begin
                if (req_addr !== base + 32'(4 * got)) begin ok = 1'b0; bad = req_addr; end
                got++;
            end
            @(negedge clk);
        end
        chk(ok, {req, " addr sequence"}, bad, base);
        chk(got == exp_n, {req, " request count"}, got, exp_n);
        chk(req_valid == 1'b0, "R7 idle after frame", req_valid, 0);
    endtask

    task automatic t_reset();
        chk(cur_base == 0, "R1 cur_base", cur_base, 0);
        chk(req_valid == 0, "R1 req_valid", req_valid, 0);
        // pending base is 0: promoting it without a write yields 0
        xfer_cfg = 32'h0000_0000;
        pulse_fs();
        chk(cur_base == 0, "R1 pending base", cur_base, 0);
    endtask

    task automatic t_promote32();
        pix32 = 1'b1; xfer_cfg = {16'd2, 16'd3};
        wr_base(32'h1000_0000);
        repeat (2) @(negedge clk);
        chk(cur_base == 0, "R2 write does not move cur_base", cur_base, 0);
        pulse_fs();
        chk(cur_base == 32'h1000_0000, "R3 promote", cur_base, 32'h1000_0000);
        collect(32'h1000_0000, 6, "R5 R4 wide");
    endtask

    task automatic t_last_wins();
        pix32 = 1'b1; xfer_cfg = {16'd1, 16'd4};
        wr_base(32'h2000_0000);
        wr_base(32'h3000_0000);
        wr_base(32'h4000_0100);
        chk(cur_base == 32'h1000_0000, "R2 held over writes", cur_base, 32'h1000_0000);
        pulse_fs();
        chk(cur_base == 32'h4000_0100, "R3 last write wins", cur_base, 32'h4000_0100);
        collect(32'h4000_0100, 4, "R4 last wins frame");
    endtask

    task automatic t_narrow();
        pix32 = 1'b0; xfer_cfg = {16'd2, 16'd5};
        wr_base(32'h0000_8000);
        pulse_fs();
        collect(32'h0000_8000, 6, "R6 odd width");
        xfer_cfg = {16'd3, 16'd4};
        pulse_fs();
        collect(32'h0000_8000, 6, "R6 even width");
    endtask

    task automatic t_stall();
        pix32 = 1'b1; xfer_cfg = {16'd1, 16'd3};
        wr_base(32'h0000_0400);
        req_ready = 1'b0;
        pulse_fs();
        for (int i = 0; i < 3; i++) begin
            chk(req_valid == 1'b1, "R8 valid held", req_valid, 1);
            chk(req_addr == 32'h0000_0400, "R8 addr held", req_addr, 32'h0000_0400);
            @(negedge clk);
        end
        collect(32'h0000_0400, 3, "R8 after stall");
    endtask

    task automatic t_zero();
        pix32 = 1'b1; xfer_cfg = {16'd4, 16'd0};
        pulse_fs();
        collect(32'h0000_0400, 0, "R9 zero width");
        xfer_cfg = {16'd0, 16'd8};
        pulse_fs();
        collect(32'h0000_0400, 0, "R9 zero lines");
    endtask

    task automatic t_restart();
        pix32 = 1'b1; xfer_cfg = {16'd1, 16'd8};
        wr_base(32'h0001_0000);
        req_ready = 1'b1;
        pulse_fs();
        repeat (3) @(negedge clk);
        chk(req_valid == 1'b1, "R10 mid-frame", req_valid, 1);
        wr_base(32'h0002_0000);
        xfer_cfg = {16'd1, 16'd2};
        pulse_fs();
        chk(cur_base == 32'h0002_0000, "R10 restart base", cur_base, 32'h0002_0000);
        collect(32'h0002_0000, 2, "R10 restart frame");
    endtask

    task automatic t_sample();
        pix32 = 1'b1; xfer_cfg = {16'd2, 16'd4};
        req_ready = 1'b0;
        pulse_fs();
        xfer_cfg = {16'd1, 16'd1};
        pix32 = 1'b0;
        collect(32'h0002_0000, 8, "R11 sizes sampled at start");
    endtask

    task automatic t_align();
        pix32 = 1'b1; xfer_cfg = {16'd1, 16'd2};
        wr_base(32'h0005_0003);
        pulse_fs();
        chk(cur_base == 32'h0005_0000, "R12 base aligned", cur_base, 32'h0005_0000);
        collect(32'h0005_0000, 2, "R12 aligned addresses");
    endtask

    initial begin
        rst = 1'b1; nb_we = 1'b0; nb_wdata = '0; xfer_cfg = '0;
        pix32 = 1'b0; frame_start = 1'b0; req_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_promote32();
        t_last_wins();
        t_narrow();
        t_stall();
        t_zero();
        t_restart();
        t_sample();
        t_align();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule